// File: doc/BRIEF.md
# E1 Receive System-Side Clock-Master Timing

This block drives the system side of one E1 receive link when the link itself sources the timing. From a clock running at twice the E1 bit rate it makes a 2.048 MHz output clock, a serial payload stream, a serial signaling stream and a frame pulse. Each frame has 256 bit periods, 32 timeslots of 8 bits. The block does not store payload. On every cycle it shows on `fetch_ts_o` the timeslot it needs, and the surrounding logic must return that timeslot's byte and signaling nibble in the same cycle.

In full operation the output clock never stops. In fractional operation the high phase of the clock is dropped for the timeslots chosen by a 32-bit mask, for the eighth bit of every timeslot, or for both. Bits sent while the clock is dropped are don't-care.

The frame pulse can mark every frame, the start of a CRC multiframe, the start of a signaling multiframe, either multiframe start, or the two overhead timeslots. Its polarity is configurable. Each of the frame pulse and the data pair (payload and signaling) has its own choice of update edge. When the two choices differ, the pulse leads the data by half a bit period.

Top module: `e1_rx_sys_master`

## Requirements
- R1: While reset is held, `rck_o`, `rdat_o` and `rsig_o` are 0 and `rfp_o` equals `cfg_fp_inv`.
- R2: With `cfg_gap_ts` and `cfg_gap_b8` both 0, every bit period is two `clk` cycles with `rck_o` high in the first and low in the second. This runs without interruption over all 256 bit periods of every frame.
- R3: With `cfg_gap_ts` = 1, `rck_o` stays low for all 8 bit periods of any timeslot t whose `ts_gap_mask[t]` is 1.
- R4: With `cfg_gap_b8` = 1, `rck_o` stays low during bit 8 (the last bit) of every timeslot. With both gap bits set, the gapped periods are the union of R3 and R4.
- R5: `rdat_o` sends the byte returned on `pay_i` for the timeslot shown on `fetch_ts_o`, MSB (`pay_i[7]`) in bit 1 of the timeslot and LSB in bit 8. With `cfg_data_fall` = 0, each bit appears on the rising edge of `rck_o` at the start of its bit period.
- R6: With `cfg_data_fall` = 1, each data and signaling bit appears half a bit period later, on the falling edge within its own bit period.
- R7: `rsig_o` is 0 in bits 1 to 4 of each timeslot and carries `sig_nib_i[3]`, `[2]`, `[1]`, `[0]` in bits 5 to 8. It updates on the same edge as `rdat_o`.
- R8: The frame pulse is active for exactly one bit period, at bit 1 of the marked timeslot 0. With `cfg_fp_fall` = 0 it changes at the start of that bit period. With `cfg_fp_fall` = 1 it changes half a bit period earlier.
- R9: With `cfg_fp_ovh` = 1, the pulse is active for the whole of timeslot 1 and the whole of timeslot 16 of every frame.
- R10: With `cfg_fp_ovh` = 0, {`cfg_fp_smf`,`cfg_fp_cmf`} chooses which frames are marked:
  - 00: every frame.
  - 01: frames whose `crc_frm_i` is 0.
  - 10: frames whose `sig_frm_i` is 0.
  - 11: frames where either counter is 0.

  Both counters give the number of the next frame and are sampled during the last bit period of the frame before it.
- R11: With `cfg_fp_inv` = 1 the frame pulse is active low, otherwise active high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the E1 bit rate (4.096 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_gap_ts | input | 1 | Enable gapping of masked timeslots |
| cfg_gap_b8 | input | 1 | Enable gapping of bit 8 of each timeslot |
| ts_gap_mask | input | 32 | One bit per timeslot to gap |
| cfg_data_fall | input | 1 | Data and signaling update on the falling edge |
| cfg_fp_fall | input | 1 | Frame pulse updates on the falling edge |
| cfg_fp_ovh | input | 1 | Frame pulse marks the overhead timeslots |
| cfg_fp_smf | input | 1 | Frame pulse marks signaling multiframes |
| cfg_fp_cmf | input | 1 | Frame pulse marks CRC multiframes |
| cfg_fp_inv | input | 1 | Frame pulse active low |
| crc_frm_i | input | 4 | CRC multiframe position of the next frame |
| sig_frm_i | input | 4 | Signaling multiframe position of the next frame |
| fetch_ts_o | output | 5 | Timeslot whose byte and nibble are needed now |
| pay_i | input | 8 | Payload byte for `fetch_ts_o` |
| sig_nib_i | input | 4 | Signaling nibble for `fetch_ts_o` |
| rck_o | output | 1 | Output clock, possibly gapped |
| rfp_o | output | 1 | Frame pulse |
| rdat_o | output | 1 | Serial payload |
| rsig_o | output | 1 | Serial signaling |

## Verification
The assertions check several rules on every cycle:
- In full mode the clock toggles on every cycle, and it is never high for two cycles in a row.
- The clock is never high inside a gapped timeslot or a gapped bit 8.
- In full mode data changes only on the configured clock edge, and the frame pulse changes only on its own configured edge.
- A frame-type pulse never lasts longer than one bit period.

Only the bench's scenarios can show the rest, because it depends on payload values, counter history and the whole frame's schedule:
- the MSB-first bit order and the signaling nibble placement;
- which frames a multiframe selection marks, including the next-frame sampling of the counters;
- the half-period lead of the pulse when the edges differ;
- the exact timing of the overhead window.

// File: rtl/e1rx_pkg.sv
package e1rx_pkg;
  // Frame marker selection, encoded as {signaling, crc}
  typedef enum logic [1:0] {
    MF_FRAME = 2'b00,
    MF_CRC   = 2'b01,
    MF_SIG   = 2'b10,
    MF_BOTH  = 2'b11
  } mf_sel_e;
endpackage

// File: rtl/e1rx_timebase.sv
module e1rx_timebase #(
  parameter int POS_W   = 8,
  parameter int POS_MAX = 255
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [POS_W-1:0] pos_q,
  output logic             ph_n,
  output logic [POS_W-1:0] pos_n
);
  logic ph_q;

  // next state: phase alternates, bit position advances after phase 1
  always_comb begin
    ph_n  = ~ph_q;
    pos_n = pos_q;
    if (ph_q) begin
      if (pos_q == POS_W'(POS_MAX)) pos_n = '0;
      else                          pos_n = pos_q + 1'b1;
    end
  end

  // reset parks just before bit 0 of a frame
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= 1'b1;
      pos_q <= POS_W'(POS_MAX);
    end else begin
      ph_q  <= ph_n;
      pos_q <= pos_n;
    end
  end
endmodule

// File: rtl/e1rx_gap.sv
module e1rx_gap #(
  parameter int TS_CNT = 32,
  parameter int TS_W   = 5,
  parameter int BIT_W  = 3
) (
  input  logic [TS_W+BIT_W-1:0] pos,
  input  logic                  gap_ts,
  input  logic                  gap_b8,
  input  logic [TS_CNT-1:0]     mask,
  output logic                  gapped
);
  logic [TS_W-1:0]  ts;
  logic [BIT_W-1:0] bit_ix;

  assign ts     = pos[TS_W+BIT_W-1:BIT_W];
  assign bit_ix = pos[BIT_W-1:0];
  assign gapped = (gap_ts & mask[ts]) | (gap_b8 & (bit_ix == '1));
endmodule

// File: rtl/e1rx_marker.sv
module e1rx_marker
  import e1rx_pkg::*;
#(
  parameter int TS_W     = 5,
  parameter int BIT_W    = 3,
  parameter int MF_W     = 4,
  parameter int OVH_TS_A = 1,
  parameter int OVH_TS_B = 16
) (
  input  logic [TS_W+BIT_W-1:0] pos,
  input  logic                  ovh,
  input  logic                  smf,
  input  logic                  cmf,
  input  logic [MF_W-1:0]       crc_frm,
  input  logic [MF_W-1:0]       sig_frm,
  output logic                  mark
);
  mf_sel_e         sel;
  logic [TS_W-1:0] ts;
  logic            sel_hit;

  assign sel = mf_sel_e'({smf, cmf});
  assign ts  = pos[TS_W+BIT_W-1:BIT_W];

  always_comb begin
    unique case (sel)
      MF_FRAME: sel_hit = 1'b1;
      MF_CRC:   sel_hit = (crc_frm == '0);
      MF_SIG:   sel_hit = (sig_frm == '0);
      default:  sel_hit = (crc_frm == '0) | (sig_frm == '0);
    endcase
    if (ovh) mark = (ts == TS_W'(OVH_TS_A)) | (ts == TS_W'(OVH_TS_B));
    else     mark = (pos == '0) & sel_hit;
  end
endmodule

// File: rtl/e1_rx_sys_master.sv
module e1_rx_sys_master #(
  parameter int TS_CNT   = 32,
  parameter int TS_BITS  = 8,
  parameter int SIG_BITS = 4,
  parameter int MF_W     = 4,
  parameter int OVH_TS_A = 1,
  parameter int OVH_TS_B = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_gap_ts,
  input  logic                       cfg_gap_b8,
  input  logic [TS_CNT-1:0]          ts_gap_mask,
  input  logic                       cfg_data_fall,
  input  logic                       cfg_fp_fall,
  input  logic                       cfg_fp_ovh,
  input  logic                       cfg_fp_smf,
  input  logic                       cfg_fp_cmf,
  input  logic                       cfg_fp_inv,
  input  logic [MF_W-1:0]            crc_frm_i,
  input  logic [MF_W-1:0]            sig_frm_i,
  output logic [$clog2(TS_CNT)-1:0]  fetch_ts_o,
  input  logic [TS_BITS-1:0]         pay_i,
  input  logic [SIG_BITS-1:0]        sig_nib_i,
  output logic                       rck_o,
  output logic                       rfp_o,
  output logic                       rdat_o,
  output logic                       rsig_o
);
  localparam int TS_W    = $clog2(TS_CNT);
  localparam int BIT_W   = $clog2(TS_BITS);
  localparam int SIG_W   = $clog2(SIG_BITS);
  localparam int POS_W   = TS_W + BIT_W;
  localparam int POS_MAX = TS_CNT * TS_BITS - 1;

  // reset synchronizer: asserts at once, releases on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int = rst_sync_q[1];

  logic [POS_W-1:0] pos_q, pos_n, pos_nx1;
  logic             ph_n;
  logic             gap_n;

  e1rx_timebase #(.POS_W(POS_W), .POS_MAX(POS_MAX)) u_tb (
    .clk   (clk),
    .rst_n (rst_int),
    .pos_q (pos_q),
    .ph_n  (ph_n),
    .pos_n (pos_n)
  );

  e1rx_gap #(.TS_CNT(TS_CNT), .TS_W(TS_W), .BIT_W(BIT_W)) u_gap (
    .pos    (pos_n),
    .gap_ts (cfg_gap_ts),
    .gap_b8 (cfg_gap_b8),
    .mask   (ts_gap_mask),
    .gapped (gap_n)
  );

  // marker for the upcoming bit (rising edge) and the one after it (falling edge)
  assign pos_nx1 = (pos_n == POS_W'(POS_MAX)) ? '0 : pos_n + 1'b1;

  logic [1:0] mark_v;
  generate
    for (genvar k = 0; k < 2; k++) begin : g_mark
      e1rx_marker #(
        .TS_W(TS_W), .BIT_W(BIT_W), .MF_W(MF_W),
        .OVH_TS_A(OVH_TS_A), .OVH_TS_B(OVH_TS_B)
      ) u_mark (
        .pos     ((k == 0) ? pos_n : pos_nx1),
        .ovh     (cfg_fp_ovh),
        .smf     (cfg_fp_smf),
        .cmf     (cfg_fp_cmf),
        .crc_frm (crc_frm_i),
        .sig_frm (sig_frm_i),
        .mark    (mark_v[k])
      );
    end
  endgenerate

  assign fetch_ts_o = pos_n[POS_W-1:BIT_W];

  logic [BIT_W-1:0] bit_rev;
  assign bit_rev = BIT_W'(TS_BITS - 1) - pos_n[BIT_W-1:0];

  logic ck_q, ck_d, dat_q, dat_d, sig_q, sig_d, fp_q, fp_d;
  logic ld_data, ld_fp;

  // phase 0 of the next state is a rising edge, phase 1 a falling edge
  assign ld_data = (ph_n == cfg_data_fall);
  assign ld_fp   = (ph_n == cfg_fp_fall);

  always_comb begin
    ck_d  = ~ph_n & ~gap_n;
    dat_d = dat_q;
    sig_d = sig_q;
    fp_d  = fp_q;
    if (ld_data) begin
      dat_d = pay_i[bit_rev];
      sig_d = (bit_rev < BIT_W'(SIG_BITS)) ? sig_nib_i[bit_rev[SIG_W-1:0]] : 1'b0;
    end
    if (ld_fp) fp_d = mark_v[cfg_fp_fall];
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) begin
      ck_q  <= 1'b0;
      dat_q <= 1'b0;
      sig_q <= 1'b0;
      fp_q  <= 1'b0;
    end else begin
      ck_q  <= ck_d;
      dat_q <= dat_d;
      sig_q <= sig_d;
      fp_q  <= fp_d;
    end
  end

  assign rck_o  = ck_q;
  assign rdat_o = dat_q;
  assign rsig_o = sig_q;
  assign rfp_o  = fp_q ^ cfg_fp_inv;
endmodule

// File: rtl/e1_rx_sys_master_chk.sv
module e1_rx_sys_master_chk #(
  parameter int TS_CNT = 32,
  parameter int TS_W   = 5,
  parameter int BIT_W  = 3
) (
  input logic                  clk,
  input logic                  rst_int,
  input logic                  cfg_gap_ts,
  input logic                  cfg_gap_b8,
  input logic [TS_CNT-1:0]     ts_gap_mask,
  input logic                  cfg_data_fall,
  input logic                  cfg_fp_fall,
  input logic                  cfg_fp_ovh,
  input logic                  cfg_fp_inv,
  input logic [TS_W+BIT_W-1:0] pos_q,
  input logic                  rck_o,
  input logic                  rfp_o,
  input logic                  rdat_o
);
  logic seen;
  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) seen <= 1'b0;
    else          seen <= 1'b1;
  end

  logic full_mode;
  assign full_mode = !cfg_gap_ts && !cfg_gap_b8;

  // R2
  full_clk_toggle_chk: assert property (@(posedge clk) disable iff (!rst_int)
    (seen && full_mode) |-> (rck_o != $past(rck_o)));

  // R2
  clk_high_once_chk: assert property (@(posedge clk) disable iff (!rst_int)
    rck_o |=> !rck_o);

  // R3 R4
  gap_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_int)
    rck_o |-> !((cfg_gap_ts && ts_gap_mask[pos_q[TS_W+BIT_W-1:BIT_W]]) ||
                (cfg_gap_b8 && (pos_q[BIT_W-1:0] == '1))));

  // R5 R6
  data_edge_chk: assert property (@(posedge clk) disable iff (!rst_int)
    (seen && full_mode && (rdat_o != $past(rdat_o))) |-> (rck_o == !cfg_data_fall));

  // R8
  fp_edge_chk: assert property (@(posedge clk) disable iff (!rst_int)
    (seen && full_mode && (rfp_o != $past(rfp_o))) |-> (rck_o == !cfg_fp_fall));

  // R8
  fp_width_chk: assert property (@(posedge clk) disable iff (!rst_int)
    (seen && !cfg_fp_ovh && (rfp_o != cfg_fp_inv) && ($past(rfp_o) != cfg_fp_inv))
      |=> (rfp_o == cfg_fp_inv));
endmodule

bind e1_rx_sys_master e1_rx_sys_master_chk #(
  .TS_CNT(TS_CNT), .TS_W(TS_W), .BIT_W(BIT_W)
) u_chk (
  .clk           (clk),
  .rst_int       (rst_int),
  .cfg_gap_ts    (cfg_gap_ts),
  .cfg_gap_b8    (cfg_gap_b8),
  .ts_gap_mask   (ts_gap_mask),
  .cfg_data_fall (cfg_data_fall),
  .cfg_fp_fall   (cfg_fp_fall),
  .cfg_fp_ovh    (cfg_fp_ovh),
  .cfg_fp_inv    (cfg_fp_inv),
  .pos_q         (pos_q),
  .rck_o         (rck_o),
  .rfp_o         (rfp_o),
  .rdat_o        (rdat_o)
);

// File: tb/e1_rx_sys_master_test.sv
module e1_rx_sys_master_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        gts = 0, gb8 = 0, dfall = 0, ffall = 0, ovh = 0, smf = 0, cmf = 0, inv = 0;
  logic [31:0] mask = '0;
  logic [3:0]  crc_frm = '0, sig_frm = '0;
  logic [4:0]  fetch_ts;
  logic [7:0]  pay;
  logic [3:0]  nib;
  logic        rck, rfp, rdat, rsig;

  int n_checks = 0, n_fail = 0, cyc = 0, seed = 0, crc0 = 0, sig0 = 0;

  function automatic logic [7:0] pay_of(int ts, int s);
    return 8'((ts * 29 + s * 7 + 3) & 255);
  endfunction
  function automatic logic [3:0] nib_of(int ts, int s);
    return 4'((ts ^ (s * 5)) & 15);
  endfunction

  assign pay = pay_of(int'(fetch_ts), seed);
  assign nib = nib_of(int'(fetch_ts), seed);

  e1_rx_sys_master uut (
    .clk(clk), .rst_n(rst_n), .cfg_gap_ts(gts), .cfg_gap_b8(gb8), .ts_gap_mask(mask),
    .cfg_data_fall(dfall), .cfg_fp_fall(ffall), .cfg_fp_ovh(ovh), .cfg_fp_smf(smf),
    .cfg_fp_cmf(cmf), .cfg_fp_inv(inv), .crc_frm_i(crc_frm), .sig_frm_i(sig_frm),
    .fetch_ts_o(fetch_ts), .pay_i(pay), .sig_nib_i(nib),
    .rck_o(rck), .rfp_o(rfp), .rdat_o(rdat), .rsig_o(rsig)
  );

  // reference model helpers, indexed by absolute bit number since reset
  function automatic bit gapped(int p);
    return (gts && mask[p / 8]) || (gb8 && (p % 8 == 7));
  endfunction
  function automatic bit active(int a);
    int p = a % 256;
    int f = a / 256;
    bit ch = ((crc0 + f) % 16) == 0;
    bit sh = ((sig0 + f) % 16) == 0;
    if (ovh) return (p / 8 == 1) || (p / 8 == 16);
    if (p != 0) return 0;
    case ({smf, cmf})
      2'b00:   return 1;
      2'b01:   return ch;
      2'b10:   return sh;
      default: return ch || sh;
    endcase
  endfunction
  function automatic bit dbit(int a);
    int p = a % 256;
    logic [7:0] b = pay_of(p / 8, seed);
    return b[7 - p % 8];
  endfunction
  function automatic bit sbit(int a);
    int p = a % 256;
    logic [3:0] s = nib_of(p / 8, seed);
    if (p % 8 < 4) return 0;
    return s[7 - p % 8];
  endfunction

  task automatic check(string req, string what, int act, int exp, int n);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s cycle %0d: actual %0d expected %0d", req, what, n, act, exp);
    end
  endtask

  task automatic run_scn(bit g_ts, bit g_b8, logic [31:0] m, bit df, bit ff, bit o, bit s,
                         bit c, bit iv, int sd, int c0, int s0, int frames,
                         string dtag, string fptag);
    gts = g_ts; gb8 = g_b8; mask = m; dfall = df; ffall = ff; ovh = o; smf = s; cmf = c;
    inv = iv; seed = sd; crc0 = c0; sig0 = s0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1", "rck", int'(rck), 0, -1);
    check("R1", "rdat", int'(rdat), 0, -1);
    check("R1", "rsig", int'(rsig), 0, -1);
    check("R1", "rfp", int'(rfp), int'(iv), -1);
    crc_frm = 4'(c0);
    sig_frm = 4'(s0);
    rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
    for (int n = 0; n < frames * 512; n++) begin
      int ph, p, a;
      bit exp_fp;
      string ctag;
      @(posedge clk);
      @(negedge clk);
      ph = n % 2;
      p  = (n / 2) % 256;
      // clock: R2 full, R3 timeslot gap, R4 bit-8 gap
      ctag = g_ts ? "R3" : (g_b8 ? "R4" : "R2");
      check(ctag, "rck", int'(rck), int'(ph == 0 && !gapped(p)), n);
      // data and signaling: R5 rising, R6 falling, R7 signaling
      if (df && n == 0) begin
        check(dtag, "rdat", int'(rdat), 0, n);
        check("R7", "rsig", int'(rsig), 0, n);
      end else begin
        a = df ? (n - 1) / 2 : n / 2;
        if (!gapped(a % 256)) begin
          check(dtag, "rdat", int'(rdat), int'(dbit(a)), n);
          check("R7", "rsig", int'(rsig), int'(sbit(a)), n);
        end
      end
      // frame pulse: R8 edge and width, R9 overhead, R10 multiframe, R11 polarity
      if (ff && n == 0) exp_fp = 0;
      else exp_fp = active(ff ? (n + 1) / 2 : n / 2);
      check(fptag, "rfp", int'(rfp), int'(exp_fp ^ iv), n);
      if (n % 512 == 0) begin
        crc_frm = 4'((c0 + n / 512 + 1) % 16);
        sig_frm = 4'((s0 + n / 512 + 1) % 16);
      end
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected at most 200000", cyc);
      finish_run();
    end
  end

  initial begin
    // R5 full clock, rising data, R8 basic frame pulse on rising edge
    run_scn(0, 0, 32'h0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 2, "R5", "R8");
    // R6 falling data, R10 CRC multiframe marking
    run_scn(0, 0, 32'h0, 1, 0, 0, 0, 1, 0, 2, 14, 5, 6, "R6", "R10");
    // R3 timeslot gap, R8 pulse leading on falling edge, signaling multiframe
    run_scn(1, 0, 32'hA500_F012, 0, 1, 0, 1, 0, 0, 3, 7, 13, 6, "R5", "R8");
    // R4 bit-8 gap, both multiframes, R11 inverted polarity
    run_scn(0, 1, 32'hFFFF_FFFF, 1, 1, 0, 1, 1, 1, 4, 15, 12, 6, "R6", "R11");
    // R9 overhead window with both gaps active
    run_scn(1, 1, 32'h0001_8006, 0, 0, 1, 1, 1, 0, 5, 0, 0, 2, "R5", "R9");
    finish_run();
  end
endmodule